// File: doc/BRIEF.md
# Sinc-cubed decimation filter

This block turns the one-bit output stream of a sigma-delta modulator into signed PCM words. Every bit that arrives with its enable is mapped to +1 or -1 and pushed through three cascaded integrators. Once per decimation period, three cascaded first-order differences run on the decimated integrator value. Together they form a cube-of-boxcar low-pass response of length equal to the decimation ratio. The ratio is chosen at run time from 32, 64, 128 and 256, and the filter's word growth changes with it.

The filter result is scaled down to a 15-bit two's-complement value by dropping low bits. It is then packed into a 16-bit word in one of two ways. In wide mode the value is shifted up one place with a zero LSB. In flagged mode the top bit is kept clear as a data marker and the value sits in the low 15 bits. A positive full-scale input saturates to the largest code. A strobe marks each new word, and a settled flag tells the consumer whether the filter history behind that word was complete.

Top module: `sinc3_decim`

## Requirements
- R1: While rst_ni is low, data_o is 0, strobe_o is 0 and settled_o is 0.
- R2: rate_sel_i values 0, 1, 2 and 3 select ratios R of 32, 64, 128 and 256 enabled bits per output. strobe_o is high for exactly one cycle, in the cycle after the clock edge that accepts the R-th enabled bit of a period.
- R3: bit_i is mapped to +1 when 1 and to -1 when 0. Bits presented while bit_en_i is low have no effect on any output, and data_o holds its value between strobes.
- R4: Each output value v is the input sequence convolved with the cube of a length-R boxcar, evaluated at the latest enabled bit. Bits before the last reset or clear count as zero.
- R5: The 15-bit result is floor(v / 2^(3*log2(R) - 14)). An all-zero input therefore gives -16384.
- R6: With mode_i = 0 (wide mode), data_o is the 15-bit result shifted left one place with bit 0 equal to 0.
- R7: When v equals +R^3 (positive full scale), data_o is 0x7FFF in wide mode and 0x3FFF in flagged mode.
- R8: With mode_i = 1 (flagged mode), data_o[15] is 0 and data_o[14:0] holds the 15-bit result.
- R9: A change of rate_sel_i clears all filter state and the period counter on the next edge. An enabled bit in that same cycle is discarded, and no strobe follows that edge.
- R10: The first three outputs after reset or after a rate change carry settled_o = 0. Every later output carries settled_o = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Modulator output bit |
| bit_en_i | input | 1 | Qualifies bit_i for this cycle |
| rate_sel_i | input | 2 | Decimation ratio select (32 << rate_sel_i) |
| mode_i | input | 1 | 0 = wide 16-bit word, 1 = flagged 15-bit word |
| data_o | output | 16 | Output word, valid when strobe_o is high |
| strobe_o | output | 1 | One-cycle pulse per new output word |
| settled_o | output | 1 | Filter history behind data_o is complete |

## Verification
A rate change can land in the same cycle as the enabled bit that would close a decimation period. This creates a race between the clear and the output capture. The bench runs 95 bits at ratio 32, then switches to ratio 64 while presenting the 96th enabled bit on that same edge. It expects no strobe, the bit to be dropped, and the next outputs to match a model restarted from empty history, with settled_o low for three words. The saturation compare and the LSB packing also coincide on every strobe. Constant-one streams in both modes check that only full scale produces an odd wide-mode code.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;

  localparam int unsigned N_STG = 3;

  typedef enum logic {
    FMT_WIDE = 1'b0,
    FMT_FLAG = 1'b1
  } fmt_e;

endpackage

// File: rtl/sinc3_integ.sv
module sinc3_integ
  import sinc3_pkg::*;
#(
  parameter int unsigned ACC_W = 26
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    en_i,
  input  logic                    bit_i,
  output logic signed [ACC_W-1:0] sum_o
);

  logic signed [ACC_W-1:0] x;
  logic signed [ACC_W-1:0] acc_q [N_STG];
  logic signed [ACC_W-1:0] nxt   [N_STG];

  assign x = bit_i ? ACC_W'(1) : {ACC_W{1'b1}};

  // chained without pipeline delay: last stage is a pure triple sum
  always_comb begin
    nxt[0] = acc_q[0] + x;
    for (int s = 1; s < N_STG; s++) nxt[s] = acc_q[s] + nxt[s-1];
  end

  for (genvar g = 0; g < N_STG; g++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    acc_q[g] <= '0;
      else if (clr_i) acc_q[g] <= '0;
      else if (en_i)  acc_q[g] <= nxt[g];
    end
  end

  assign sum_o = nxt[N_STG-1];

endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb
  import sinc3_pkg::*;
#(
  parameter int unsigned ACC_W = 26
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    dec_i,
  input  logic signed [ACC_W-1:0] din_i,
  output logic signed [ACC_W-1:0] dout_o
);

  logic signed [ACC_W-1:0] dly_q [N_STG];
  logic signed [ACC_W-1:0] diff  [N_STG];

  always_comb begin
    diff[0] = din_i - dly_q[0];
    for (int s = 1; s < N_STG; s++) diff[s] = diff[s-1] - dly_q[s];
  end

  for (genvar g = 0; g < N_STG; g++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    dly_q[g] <= '0;
      else if (clr_i) dly_q[g] <= '0;
      else if (dec_i) dly_q[g] <= (g == 0) ? din_i : diff[(g == 0) ? 0 : g-1];
    end
  end

  assign dout_o = diff[N_STG-1];

endmodule

// File: rtl/sinc3_ctrl.sv
module sinc3_ctrl
  import sinc3_pkg::*;
#(
  parameter int unsigned MIN_LOG2 = 5,
  parameter int unsigned SEL_W    = 2,
  parameter int unsigned MAX_LOG2 = 8,
  parameter int unsigned LG_W     = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] rate_sel_i,
  output logic             clr_o,
  output logic             dec_o,
  output logic [LG_W-1:0]  lg_o,
  output logic             settled_o
);

  localparam int unsigned CNT_W = MAX_LOG2;
  localparam int unsigned SET_W = $clog2(N_STG + 1);

  logic [SEL_W-1:0] rate_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  logic [SET_W-1:0] settle_q;

  assign clr_o = (rate_sel_i != rate_q);
  assign lim   = CNT_W'((1 << (MIN_LOG2 + int'(rate_q))) - 1);
  assign dec_o = en_i && !clr_o && (cnt_q == lim);
  assign lg_o  = LG_W'(MIN_LOG2) + LG_W'(rate_q);
  assign settled_o = (settle_q == SET_W'(N_STG));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q   <= '0;
      cnt_q    <= '0;
      settle_q <= '0;
    end else if (clr_o) begin
      rate_q   <= rate_sel_i;
      cnt_q    <= '0;
      settle_q <= '0;
    end else if (en_i) begin
      cnt_q <= (cnt_q == lim) ? '0 : cnt_q + 1'b1;
      if (dec_o && !settled_o) settle_q <= settle_q + 1'b1;
    end
  end

endmodule

// File: rtl/sinc3_fmt.sv
module sinc3_fmt
  import sinc3_pkg::*;
#(
  parameter int unsigned ACC_W = 26,
  parameter int unsigned LG_W  = 4,
  parameter int unsigned RES_W = 15
) (
  input  logic signed [ACC_W-1:0] val_i,
  input  logic [LG_W-1:0]         lg_i,
  input  logic                    mode_i,
  output logic [RES_W:0]          word_o
);

  localparam logic signed [ACC_W-1:0] POS_MAX = ACC_W'((1 << (RES_W - 1)) - 1);

  fmt_e                    fm;
  int                      shamt;
  logic signed [ACC_W-1:0] scaled;
  logic                    sat;

  assign fm     = fmt_e'(mode_i);
  assign shamt  = N_STG * int'(lg_i) - (int'(RES_W) - 1);
  assign scaled = val_i >>> shamt;
  assign sat    = scaled > POS_MAX;

  always_comb begin
    unique case (fm)
      FMT_WIDE: word_o = sat ? {1'b0, {RES_W{1'b1}}} : {scaled[RES_W-1:0], 1'b0};
      FMT_FLAG: word_o = sat ? {2'b00, {(RES_W-1){1'b1}}} : {1'b0, scaled[RES_W-1:0]};
      default:  word_o = '0;
    endcase
  end

endmodule

// File: rtl/sinc3_decim.sv
module sinc3_decim
  import sinc3_pkg::*;
#(
  parameter int unsigned MIN_LOG2 = 5,
  parameter int unsigned SEL_W    = 2,
  parameter int unsigned RES_W    = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_i,
  input  logic             bit_en_i,
  input  logic [SEL_W-1:0] rate_sel_i,
  input  logic             mode_i,
  output logic [RES_W:0]   data_o,
  output logic             strobe_o,
  output logic             settled_o
);

  localparam int unsigned MAX_LOG2 = MIN_LOG2 + (1 << SEL_W) - 1;
  // one bit above growth so +R^3 is representable for the saturation compare
  localparam int unsigned ACC_W    = N_STG * MAX_LOG2 + 2;
  localparam int unsigned LG_W     = $clog2(MAX_LOG2 + 1);

  logic                    clr, dec, ok_now;
  logic [LG_W-1:0]         lg;
  logic signed [ACC_W-1:0] integ_sum, comb_out;
  logic [RES_W:0]          word;

  sinc3_ctrl #(
    .MIN_LOG2(MIN_LOG2), .SEL_W(SEL_W), .MAX_LOG2(MAX_LOG2), .LG_W(LG_W)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(bit_en_i), .rate_sel_i(rate_sel_i),
    .clr_o(clr), .dec_o(dec), .lg_o(lg), .settled_o(ok_now)
  );

  sinc3_integ #(.ACC_W(ACC_W)) u_integ (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .en_i(bit_en_i),
    .bit_i(bit_i), .sum_o(integ_sum)
  );

  sinc3_comb #(.ACC_W(ACC_W)) u_comb (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .dec_i(dec),
    .din_i(integ_sum), .dout_o(comb_out)
  );

  sinc3_fmt #(.ACC_W(ACC_W), .LG_W(LG_W), .RES_W(RES_W)) u_fmt (
    .val_i(comb_out), .lg_i(lg), .mode_i(mode_i), .word_o(word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o    <= '0;
      strobe_o  <= 1'b0;
      settled_o <= 1'b0;
    end else if (clr) begin
      strobe_o  <= 1'b0;
      settled_o <= 1'b0;
    end else if (dec) begin
      data_o    <= word;
      strobe_o  <= 1'b1;
      settled_o <= ok_now;
    end else begin
      strobe_o  <= 1'b0;
    end
  end

endmodule

// File: rtl/sinc3_decim_chk.sv
module sinc3_decim_chk #(
  parameter int unsigned SEL_W = 2,
  parameter int unsigned RES_W = 15
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bit_en_i,
  input logic [SEL_W-1:0] rate_sel_i,
  input logic             mode_i,
  input logic [RES_W:0]   data_o,
  input logic             strobe_o,
  input logic             settled_o
);

  a_r2_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o);

  a_r2_strobe_after_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> $past(bit_en_i));

  a_r6_odd_only_full_scale: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_o && !$past(mode_i) && data_o[0]) |-> (data_o == {1'b0, {RES_W{1'b1}}}));

  a_r8_flag_bit_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_o && $past(mode_i)) |-> !data_o[RES_W]);

  a_r9_change_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_sel_i != $past(rate_sel_i)) |=> !strobe_o);

  a_r10_change_unsettled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_sel_i != $past(rate_sel_i)) |=> !settled_o);

endmodule

bind sinc3_decim sinc3_decim_chk #(.SEL_W(SEL_W), .RES_W(RES_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bit_en_i(bit_en_i), .rate_sel_i(rate_sel_i),
  .mode_i(mode_i), .data_o(data_o), .strobe_o(strobe_o), .settled_o(settled_o)
);

// File: tb/sinc3_decim_bench.sv
module sinc3_decim_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_in = 1'b0;
  logic        bit_en = 1'b0;
  logic        mode = 1'b0;
  logic [1:0]  rate = 2'd0;
  logic [15:0] data;
  logic        strobe, settled;

  always #10 clk = ~clk;

  sinc3_decim u_sinc3_decim (
    .clk_i(clk), .rst_ni(rst_n), .bit_i(bit_in), .bit_en_i(bit_en),
    .rate_sel_i(rate), .mode_i(mode), .data_o(data), .strobe_o(strobe),
    .settled_o(settled)
  );

  // {rate[21:20], mode[19], pattern[18:17], check_const[16], expected[15:0]}
  localparam logic [21:0] VEC [8] = '{
    {2'd0, 1'b0, 2'd1, 1'b1, 16'h7FFF},
    {2'd3, 1'b0, 2'd0, 1'b1, 16'h8000},
    {2'd1, 1'b1, 2'd0, 1'b1, 16'h4000},
    {2'd2, 1'b1, 2'd1, 1'b1, 16'h3FFF},
    {2'd0, 1'b0, 2'd2, 1'b0, 16'h0000},
    {2'd3, 1'b1, 2'd3, 1'b0, 16'h0000},
    {2'd1, 1'b0, 2'd3, 1'b0, 16'h0000},
    {2'd2, 1'b0, 2'd2, 1'b0, 16'h0000}
  };

  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;
  logic        hist [0:4095];
  longint      h [0:767];
  int          n_s, rr, out_idx, cur_rate;
  logic        cur_mode;
  logic [15:0] last_w;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_restart(input int r_sel, input logic m);
    longint h2 [0:511];
    cur_rate = r_sel;
    cur_mode = m;
    rr = 32 << r_sel;
    n_s = 0;
    out_idx = 0;
    for (int k = 0; k < 2*rr-1; k++) begin
      h2[k] = k + 1;
      if (h2[k] > rr) h2[k] = rr;
      if (h2[k] > 2*rr-1-k) h2[k] = 2*rr-1-k;
    end
    for (int k = 0; k < 3*rr-2; k++) begin
      h[k] = 0;
      for (int j = 0; j < rr; j++)
        if (k-j >= 0 && k-j < 2*rr-1) h[k] += h2[k-j];
    end
  endtask

  function automatic longint model_v();
    longint s = 0;
    for (int k = 0; k < 3*rr-2 && k < n_s; k++)
      s += hist[n_s-1-k] ? h[k] : -h[k];
    return s;
  endfunction

  function automatic logic [15:0] fmt(input longint v);
    int     sh = 3*(5+cur_rate) - 14;
    longint q  = v >>> sh;
    if (q > 16383) return cur_mode ? 16'h3FFF : 16'h7FFF;
    return cur_mode ? {1'b0, q[14:0]} : {q[14:0], 1'b0};
  endfunction

  function automatic logic pat_bit(input int p, input int idx);
    case (p)
      0: return 1'b0;
      1: return 1'b1;
      2: return (idx % 3) != 2;
      default: begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
      end
    endcase
  endfunction

  // called at a negedge; returns at the next negedge after checking
  task automatic step(input logic b, input logic e);
    logic        exp_s = 1'b0;
    logic        exp_ok = 1'b0;
    logic [15:0] exp_w = 16'h0;
    bit_in = b;
    bit_en = e;
    @(negedge clk);
    if (e) begin
      hist[n_s] = b;
      n_s++;
      if (n_s % rr == 0) begin
        exp_s  = 1'b1;
        exp_w  = fmt(model_v());
        exp_ok = (out_idx >= 3);
        out_idx++;
      end
    end
    check(strobe == exp_s, "R2 strobe", strobe, exp_s);
    if (exp_s) begin
      check(data == exp_w, cur_mode ? "R8 flagged word" : "R4 wide word", data, exp_w);
      check(settled == exp_ok, "R10 settled", settled, exp_ok);
      last_w = exp_w;
    end else begin
      check(data == last_w, "R3 hold", data, last_w);
    end
  endtask

  task automatic do_reset(input int r_sel, input logic m);
    bit_en = 1'b0;
    rate = 2'(r_sel);
    mode = m;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(data == 16'h0, "R1 data", data, 0);
    check(strobe == 1'b0, "R1 strobe", strobe, 0);
    check(settled == 1'b0, "R1 settled", settled, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    model_restart(r_sel, m);
    last_w = 16'h0;
  endtask

  initial begin
    @(negedge clk);
    for (int v = 0; v < 8; v++) begin
      logic [21:0] e = VEC[v];
      do_reset(int'(e[21:20]), e[19]);
      for (int i = 0; i < 6*rr; i++) begin
        step(pat_bit(int'(e[18:17]), i), 1'b1);
        for (int g = 0; g < ((i % 5 == 4) ? 2 : (i % 7 == 3) ? 1 : 0); g++)
          step(~bit_in, 1'b0);   // R3: toggling bit while disabled
      end
      if (e[16])
        check(data == e[15:0], e[17] ? "R7 full scale" : "R5 negative full scale", data, e[15:0]);
    end

    // R3: long disabled stretch leaves output untouched
    for (int g = 0; g < 40; g++) step(g[0], 1'b0);

    // R9: rate change on the edge that would close a period
    do_reset(0, 1'b0);
    for (int i = 0; i < 95; i++) step(1'b1, 1'b1);
    rate = 2'd1;
    bit_in = 1'b1;
    bit_en = 1'b1;
    @(negedge clk);
    check(strobe == 1'b0, "R9 no strobe on change", strobe, 0);
    bit_en = 1'b0;
    model_restart(1, 1'b0);
    for (int i = 0; i < 4*rr; i++) step(pat_bit(2, i), 1'b1);
    check(settled == 1'b1, "R10 fourth output settled", settled, 1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R2 watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule